// File: doc/BRIEF.md
# Fast-to-Slow Event and Address Crossing

This block carries a single-cycle event, together with an address that belongs to it, from a fast clock domain into a slower clock domain whose clock is unrelated to the fast one. In the fast domain, a counter-driven state machine accepts the event and latches the address into a holding register. It then drives a clean, registered level for a fixed number of fast cycles, followed by a guard interval of the same length. The holding register does not change during the level or the guard interval.

In the slow domain, three flip-flops in series synchronize that level. A fourth flip-flop feeds a rising-edge detector. The resulting one-slow-cycle strobe loads the held address into the output register and raises a valid pulse that lasts one slow cycle.

The fast side does not drop or merge an event that arrives while a crossing is still in flight. It refuses the event and reports the refusal on a reject strobe, and it shows the in-flight interval on a busy level. The level length is a parameter. Elaboration refuses any value below twice the slow-to-fast period ratio, rounded up, plus one.

Top module: `fast_to_slow_xfer`

## Requirements
- R1: A synchronous `src_rst` makes `src_busy` and `src_reject` 0. While `dst_clr` is high, `dst_valid` and `dst_addr` are 0, and this takes effect without waiting for a `dst_clk` edge.
- R2: An event is accepted when `src_evt` is high at a `src_clk` edge while `src_busy` is low. From that edge, `src_busy` is high for exactly 2×STRETCH_CYCLES fast cycles.
- R3: Each accepted event produces exactly one `dst_valid` pulse, and that pulse lasts one `dst_clk` cycle.
- R4: While `dst_valid` is high, `dst_addr` equals the `src_addr` value sampled at the accepting edge. Changes on `src_addr` after that edge have no effect on the delivered value.
- R5: `dst_addr` changes only together with a `dst_valid` pulse or a clear. Between pulses it holds its value.
- R6: When `src_evt` is high at an edge where `src_busy` is high, `src_reject` is high for the following fast cycle. That event is never delivered, and it does not alter the address of the crossing in flight.
- R7: An event offered in the first fast cycle after `src_busy` falls is accepted and delivered.
- R8: Asserting `dst_clr` during an idle period clears the outputs at once. After `dst_clr` is released, crossings work normally.
- R9: `src_rst` asserted during a crossing returns `src_busy` to 0 at the next `src_clk` edge.
- R10: `dst_valid` rises no more than 7 `dst_clk` cycles after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Fast clock |
| src_rst | input | 1 | Synchronous active-high reset, fast domain |
| src_evt | input | 1 | One-cycle event request, fast domain |
| src_addr | input | ADDR_W | Address sampled when an event is accepted |
| src_busy | output | 1 | High while a crossing's level or guard interval runs |
| src_reject | output | 1 | One-cycle flag: an event arrived while busy and was refused |
| dst_clk | input | 1 | Slow clock |
| dst_clr | input | 1 | Asynchronous active-high clear, slow domain |
| dst_valid | output | 1 | One-slow-cycle strobe per delivered event |
| dst_addr | output | ADDR_W | Captured address, held between strobes |

## Verification
The embedded properties check the fast-side protocol on every cycle: acceptance raises busy, refusal raises the reject flag, the level stays inside the busy window, and the held address is stable while busy. On the slow side they check that the strobe never lasts two cycles and that the output address moves only on a strobe.

Whether every accepted event gives exactly one strobe carrying its own address can only be shown by the bench's scenarios, because the clocks run at a non-integer period ratio. The same holds for the latency bound, for refused events never appearing, and for behaviour across a mid-flight reset or an asynchronous clear.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HIGH  = 2'd1,
        ST_GUARD = 2'd2
    } stretch_state_e;

    // Fewest fast cycles the level must last so the slow clock samples it:
    // twice the period ratio, rounded up, plus one.
    function automatic int min_stretch(input int fast_ps, input int slow_ps);
        return ((2 * slow_ps) + fast_ps - 1) / fast_ps + 1;
    endfunction

    function automatic int cnt_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/evt_stretcher.sv
module evt_stretcher
    import xfer_pkg::*;
#(
    parameter int ADDR_W         = 16,
    parameter int STRETCH_CYCLES = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              level,
    output logic [ADDR_W-1:0] held_addr,
    output logic              busy,
    output logic              reject
);

    localparam int               CNT_W    = cnt_width(STRETCH_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STRETCH_CYCLES - 1);

    stretch_state_e    state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              level_q;
    logic [ADDR_W-1:0] held_q;
    logic              reject_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            level_q  <= 1'b0;
            held_q   <= '0;
            reject_q <= 1'b0;
        end else begin
            reject_q <= evt && (state_q != ST_IDLE);
            case (state_q)
                ST_IDLE: begin
                    if (evt) begin
                        held_q  <= addr_in;
                        level_q <= 1'b1;
                        cnt_q   <= CNT_LAST;
                        state_q <= ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (cnt_q == '0) begin
                        level_q <= 1'b0;
                        cnt_q   <= CNT_LAST;
                        state_q <= ST_GUARD;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_GUARD: begin
                    if (cnt_q == '0) state_q <= ST_IDLE;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign level     = level_q;
    assign held_addr = held_q;
    assign busy      = (state_q != ST_IDLE);
    assign reject    = reject_q;

    // R2: acceptance opens the busy window on the next cycle
    a_r2_accept_busy: assert property (@(posedge clk) disable iff (rst)
        (evt && !busy) |=> busy);

    // R2: the crossing level only exists inside the busy window
    a_r2_level_in_busy: assert property (@(posedge clk) disable iff (rst)
        level |-> busy);

    // R6: an event during busy is flagged on the following cycle
    a_r6_reject_flag: assert property (@(posedge clk) disable iff (rst)
        (evt && busy) |=> reject);

    // R4/R6: the held address never moves once a crossing is in flight
    a_r4_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(held_addr));

endmodule

// File: rtl/level_sync.sv
module level_sync #(
    parameter int SYNC_STAGES = 3
) (
    input  logic clk,
    input  logic clr,
    input  logic din,
    output logic strobe
);

    localparam int CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    generate
        if (SYNC_STAGES < 3) begin : g_bad_depth
            $error("level_sync needs at least three synchronizer stages");
        end
        for (genvar i = 0; i < CHAIN; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or posedge clr) begin
                    if (clr) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or posedge clr) begin
                    if (clr) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    // Only the last synchronizer stage and the edge stage behind it are used.
    assign strobe = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

    // R3: the edge detector never produces a two-cycle strobe
    a_r3_strobe_single: assert property (@(posedge clk) disable iff (clr)
        strobe |=> !strobe);

endmodule

// File: rtl/bus_capture.sv
module bus_capture #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              strobe,
    input  logic [ADDR_W-1:0] bus_in,
    output logic              valid,
    output logic [ADDR_W-1:0] addr
);

    logic              valid_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
        end else begin
            valid_q <= strobe;
            if (strobe) addr_q <= bus_in;
        end
    end

    assign valid = valid_q;
    assign addr  = addr_q;

    // R5: without a strobe the captured address stays put
    a_r5_addr_hold: assert property (@(posedge clk) disable iff (clr)
        !strobe |=> $stable(addr));

    // R3: a valid pulse is always one cycle long
    a_r3_valid_single: assert property (@(posedge clk) disable iff (clr)
        valid |=> !valid);

endmodule

// File: rtl/fast_to_slow_xfer.sv
module fast_to_slow_xfer
    import xfer_pkg::*;
#(
    parameter int ADDR_W         = 16,
    parameter int FAST_PS        = 8000,
    parameter int SLOW_PS        = 27000,
    parameter int STRETCH_CYCLES = 10,
    parameter int SYNC_STAGES    = 3
) (
    input  logic              src_clk,
    input  logic              src_rst,
    input  logic              src_evt,
    input  logic [ADDR_W-1:0] src_addr,
    output logic              src_busy,
    output logic              src_reject,
    input  logic              dst_clk,
    input  logic              dst_clr,
    output logic              dst_valid,
    output logic [ADDR_W-1:0] dst_addr
);

    localparam int NEED = min_stretch(FAST_PS, SLOW_PS);

    generate
        if (STRETCH_CYCLES < NEED) begin : g_short_stretch
            $error("STRETCH_CYCLES below the minimum for the clock ratio");
        end
    endgenerate

    logic              x_level;
    logic [ADDR_W-1:0] x_addr;
    logic              x_strobe;

    evt_stretcher #(
        .ADDR_W         (ADDR_W),
        .STRETCH_CYCLES (STRETCH_CYCLES)
    ) u_stretch (
        .clk       (src_clk),
        .rst       (src_rst),
        .evt       (src_evt),
        .addr_in   (src_addr),
        .level     (x_level),
        .held_addr (x_addr),
        .busy      (src_busy),
        .reject    (src_reject)
    );

    level_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (dst_clk),
        .clr    (dst_clr),
        .din    (x_level),
        .strobe (x_strobe)
    );

    bus_capture #(
        .ADDR_W (ADDR_W)
    ) u_cap (
        .clk    (dst_clk),
        .clr    (dst_clr),
        .strobe (x_strobe),
        .bus_in (x_addr),
        .valid  (dst_valid),
        .addr   (dst_addr)
    );

endmodule

// File: tb/fast_to_slow_xfer_test.sv
`timescale 1ns/100ps
module fast_to_slow_xfer_test;

    localparam int ADDR_W  = 16;
    localparam int STRETCH = 10;

    logic              src_clk = 1'b0;
    logic              dst_clk = 1'b0;
    logic              src_rst = 1'b1;
    logic              dst_clr = 1'b1;
    logic              src_evt = 1'b0;
    logic [ADDR_W-1:0] src_addr = '0;
    logic              src_busy, src_reject, dst_valid;
    logic [ADDR_W-1:0] dst_addr;

    always #4    src_clk = ~src_clk;   // 125 MHz
    always #13.5 dst_clk = ~dst_clk;   // 27 ns, non-integer ratio

    fast_to_slow_xfer #(
        .ADDR_W(ADDR_W), .FAST_PS(8000), .SLOW_PS(27000),
        .STRETCH_CYCLES(STRETCH), .SYNC_STAGES(3)
    ) uut (
        .src_clk(src_clk), .src_rst(src_rst), .src_evt(src_evt),
        .src_addr(src_addr), .src_busy(src_busy), .src_reject(src_reject),
        .dst_clk(dst_clk), .dst_clr(dst_clr), .dst_valid(dst_valid),
        .dst_addr(dst_addr)
    );

    int checks = 0;
    int fails  = 0;
    int ne = 0;
    int ng = 0;
    logic [ADDR_W-1:0] exp_a [64];
    logic [ADDR_W-1:0] got_a [64];
    logic prev_valid = 1'b0;

    localparam logic [ADDR_W-1:0] VEC_ADDR [8] = '{
        16'h1234, 16'hFFFF, 16'h0001, 16'hA5A5,
        16'h5A5A, 16'h8000, 16'h7FFF, 16'hC3C3
    };
    localparam int VEC_GAP [8] = '{0, 3, 0, 7, 1, 0, 12, 2};

    task automatic check(input string req, input logic ok,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
        end
    endtask

    // Slow-domain monitor: record every strobe, reject two-cycle strobes (R3)
    always @(negedge dst_clk) begin
        if (dst_valid) begin
            check("R3 single-cycle strobe", !prev_valid, 64'(prev_valid), 0);
            if (ng < 64) got_a[ng] = dst_addr;
            ng++;
        end
        prev_valid = dst_valid;
    end

    // Offer an event with address a once idle; scramble the bus afterwards (R4)
    task automatic send(input logic [ADDR_W-1:0] a);
        while (src_busy) @(negedge src_clk);
        src_evt  = 1'b1;
        src_addr = a;
        @(negedge src_clk);
        src_evt  = 1'b0;
        src_addr = ~a;
        exp_a[ne] = a;
        ne++;
    endtask

    // Wait for delivery of the latest event and compare (R3, R4, R10)
    task automatic await_delivery(input string tag);
        int waited = 0;
        while (ng < ne && waited < 8) begin
            @(posedge dst_clk);
            #2;
            waited++;
        end
        check({tag, " R10 latency"}, ng == ne, 64'(ng), 64'(ne));
        if (ng == ne)
            check({tag, " R4 address"}, got_a[ne-1] == exp_a[ne-1],
                  64'(got_a[ne-1]), 64'(exp_a[ne-1]));
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        #1200000;
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", ng, ne);
        finish_run();
    end

    initial begin
        int busy_len;
        logic [ADDR_W-1:0] last;
        repeat (3) @(negedge dst_clk);
        dst_clr = 1'b0;
        repeat (2) @(negedge src_clk);
        src_rst = 1'b0;
        @(negedge src_clk);

        // R1: reset state
        check("R1 busy after reset", src_busy == 1'b0, 64'(src_busy), 0);
        check("R1 reject after reset", src_reject == 1'b0, 64'(src_reject), 0);
        check("R1 valid after clear", dst_valid == 1'b0, 64'(dst_valid), 0);
        check("R1 addr after clear", dst_addr == '0, 64'(dst_addr), 0);

        // Vector table: gaps after idle, zero gap exercises R7
        for (int i = 0; i < 8; i++) begin
            while (src_busy) @(negedge src_clk);
            repeat (VEC_GAP[i]) @(negedge src_clk);
            send(VEC_ADDR[i]);
            if (VEC_GAP[i] == 0)
                check("R7 accepted at first idle cycle", src_busy == 1'b1, 64'(src_busy), 1);
            await_delivery("vec");
        end

        // R2: busy window length
        while (src_busy) @(negedge src_clk);
        send(16'h0F0F);
        busy_len = 0;
        while (src_busy && busy_len < 100) begin
            busy_len++;
            @(negedge src_clk);
        end
        check("R2 busy length", busy_len == 2 * STRETCH, 64'(busy_len), 64'(2 * STRETCH));
        await_delivery("R2");

        // R5: output holds between strobes
        last = dst_addr;
        repeat (6) @(negedge dst_clk);
        check("R5 address held", dst_addr == last, 64'(dst_addr), 64'(last));

        // R6: event while busy is refused and not delivered
        send(16'hBEEF);
        @(negedge src_clk);
        src_evt  = 1'b1;
        src_addr = 16'hDEAD;
        @(negedge src_clk);
        src_evt = 1'b0;
        check("R6 reject flag", src_reject == 1'b1, 64'(src_reject), 1);
        @(negedge src_clk);
        check("R6 reject one cycle", src_reject == 1'b0, 64'(src_reject), 0);
        await_delivery("R6");
        while (src_busy) @(negedge src_clk);
        repeat (10) @(negedge dst_clk);
        check("R6 refused event absent", ng == ne, 64'(ng), 64'(ne));

        // R8: asynchronous clear while idle
        last = dst_addr;
        #3 dst_clr = 1'b1;
        #1;
        check("R8 clear addr immediate", dst_addr == '0, 64'(dst_addr), 0);
        check("R8 clear valid", dst_valid == 1'b0, 64'(dst_valid), 0);
        repeat (2) @(negedge dst_clk);
        dst_clr = 1'b0;
        @(negedge src_clk);
        send(16'h3C3C);
        await_delivery("R8 after clear");

        // R9: reset mid-crossing
        send(16'h6666);
        @(negedge src_clk);
        src_rst = 1'b1;
        @(negedge src_clk);
        check("R9 busy cleared by reset", src_busy == 1'b0, 64'(src_busy), 0);
        src_rst = 1'b0;
        repeat (10) @(negedge dst_clk);
        ne = ng;   // the aborted crossing may or may not have landed
        send(16'h9999);
        await_delivery("R9 after reset");

        // R3: one strobe per accepted event overall
        repeat (10) @(negedge dst_clk);
        check("R3 strobe count", ng == ne, 64'(ng), 64'(ne));
        finish_run();
    end

endmodule